// File: doc/BRIEF.md
# Watch Timer with Buzzer and Display Clock

This block divides a 32.768 kHz timekeeping tick, delivered as a one-cycle enable on the system clock, through one 14-bit binary prescaler. Three functions read that prescaler at once.

- **Interval request.** It raises a sticky request flag every 16384 ticks (half a second) or every 128 ticks (about 3.9 ms). The period is chosen by an interval select input. Software polls the flag and clears it with a one-cycle acknowledge; the flag does not force a vector.
- **Buzzer.** It drives a square wave at 2, 4, 8 or 16 kHz. The output is held low while disabled. A change of frequency is delayed until the newly chosen rate next goes high, so no shortened pulse appears.
- **Display clock.** It supplies a 512 Hz square wave to a display controller.

A synchronous clear input restarts the prescaler and drops the request flag. The oscillator and the interrupt priority logic of the processor sit outside this block.

Top module: `watch_buzz_timer`

## Requirements
- R1: After reset, irq_flag, bz_out and lcd_clk are all 0.
- R2: The prescaler advances by one only in cycles where tick_en is 1. Cycles without tick_en change neither lcd_clk nor the interval timing.
- R3: lcd_clk equals bit 5 of the prescaler (divide by 64). After a clear it is high once 32 through 63 ticks have been counted and low at 64.
- R4: With ivl_sel = 1, irq_flag becomes 1 at the tick that wraps the low 7 prescaler bits: the 128th tick after a clear. It is not set at the 127th.
- R5: With ivl_sel = 0, irq_flag becomes 1 only at the tick that wraps all 14 prescaler bits: the 16384th tick after a clear. Wraps of the low 7 bits have no effect on it.
- R6: Once set, irq_flag stays 1 until a cycle with flag_ack = 1 clears it. A new interval event in the same cycle as flag_ack leaves the flag set.
- R7: clr = 1 zeroes the prescaler and irq_flag at the next edge, overriding tick_en, interval events and flag_ack. It also loads bz_sel as the active buzzer rate at once.
- R8: While bz_en = 0, bz_out is 0.
- R9: The bz_sel encoding is 00 = 2 kHz (prescaler bit 3, period 16 ticks), 01 = 4 kHz (bit 2), 10 = 8 kHz (bit 1) and 11 = 16 kHz (bit 0, period 2 ticks). While enabled, bz_out follows the chosen bit.
- R10: A new bz_sel value (outside a clear) becomes active only at the tick where its own prescaler bit goes from 0 to 1. Until then bz_out keeps following the previously active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| clr | input | 1 | Synchronous clear of prescaler and request flag |
| ivl_sel | input | 1 | Interval select: 0 = 16384 ticks, 1 = 128 ticks |
| flag_ack | input | 1 | Write-one-to-clear pulse for the request flag |
| bz_en | input | 1 | Buzzer enable |
| bz_sel | input | 2 | Buzzer rate select (see R9) |
| irq_flag | output | 1 | Sticky interval request flag |
| bz_out | output | 1 | Buzzer square wave |
| lcd_clk | output | 1 | 512 Hz display controller clock |

## Verification
The prescaler cannot be read directly, so a wrong count shows up in three places:
- lcd_clk changes level at the wrong tick within the first 64 ticks after a clear;
- the buzzer edge counts over a 64-tick window come out wrong;
- the request flag rises one or more ticks away from tick 128 or tick 16384.

A fault in the active rate register appears only around a change of bz_sel. The output then follows the new rate too early, which the bench catches within three ticks of the change. A flag that loses its state shows at the next poll after it was set. A wrong set/acknowledge priority shows only at the one edge where both occur together.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int WT_CNT_W   = 14;  // prescaler width: full wrap = 0.5 s at 32768 Hz
  localparam int WT_FAST_W  = 7;   // fast interval: 128 ticks
  localparam int WT_LCD_TAP = 5;   // divide by 64
  localparam int WT_BZ_TOP  = 3;   // slowest buzzer tap (divide by 16)
  localparam int WT_SEL_W   = 2;

  typedef enum logic [WT_SEL_W-1:0] {
    BZ_2K  = 2'd0,
    BZ_4K  = 2'd1,
    BZ_8K  = 2'd2,
    BZ_16K = 2'd3
  } bz_rate_e;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int CNT_W  = 14,
  parameter int FAST_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             wrap_full,
  output logic             wrap_fast
);
  logic adv;

  assign adv = tick_en & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (tick_en) cnt_d = cnt_q + 1'b1;
  end

  assign wrap_full = adv & (&cnt_q);
  assign wrap_fast = adv & (&cnt_q[FAST_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wt_irq_flag.sv
module wt_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  // clear dominates; a new event beats a simultaneous acknowledge
  always_comb begin
    flag_d = flag_q;
    if (clr)          flag_d = 1'b0;
    else if (set_evt) flag_d = 1'b1;
    else if (ack)     flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/wt_buzzer.sv
module wt_buzzer #(
  parameter int CNT_W   = 14,
  parameter int SEL_W   = 2,
  parameter int TOP_TAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  input  logic             clr,
  output logic             bz_out
);
  localparam int TAP_W = $clog2(CNT_W);

  logic [SEL_W-1:0] act_q, act_d;
  logic [TAP_W-1:0] new_tap, act_tap;
  logic             new_rise;

  function automatic logic [TAP_W-1:0] tap_of(input logic [SEL_W-1:0] s);
    tap_of = TAP_W'(TOP_TAP) - TAP_W'(s);
  endfunction

  assign new_tap  = tap_of(sel);
  assign act_tap  = tap_of(act_q);
  assign new_rise = ~cnt_q[new_tap] & cnt_d[new_tap];

  // switch only when the requested tap itself rises, so no runt pulse
  always_comb begin
    act_d = act_q;
    if (clr || new_rise) act_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign bz_out = en & cnt_q[act_tap];
endmodule

// File: rtl/watch_buzz_timer.sv
module watch_buzz_timer
  import wt_pkg::*;
#(
  parameter int CNT_W   = WT_CNT_W,
  parameter int FAST_W  = WT_FAST_W,
  parameter int LCD_TAP = WT_LCD_TAP,
  parameter int BZ_TOP  = WT_BZ_TOP,
  parameter int SEL_W   = WT_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  input  logic             ivl_sel,
  input  logic             flag_ack,
  input  logic             bz_en,
  input  logic [SEL_W-1:0] bz_sel,
  output logic             irq_flag,
  output logic             bz_out,
  output logic             lcd_clk
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_full, wrap_fast, ivl_evt;

  wt_prescaler #(.CNT_W(CNT_W), .FAST_W(FAST_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(clr),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap_full(wrap_full), .wrap_fast(wrap_fast)
  );

  assign ivl_evt = ivl_sel ? wrap_fast : wrap_full;

  wt_irq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(ivl_evt), .ack(flag_ack),
    .clr(clr), .flag_q(irq_flag)
  );

  wt_buzzer #(.CNT_W(CNT_W), .SEL_W(SEL_W), .TOP_TAP(BZ_TOP)) u_bz (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_d(cnt_d), .sel(bz_sel),
    .en(bz_en), .clr(clr), .bz_out(bz_out)
  );

  assign lcd_clk = cnt_q[LCD_TAP];
endmodule

// File: rtl/wt_sva.sv
module wt_sva (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic clr,
  input logic flag_ack,
  input logic bz_en,
  input logic irq_flag,
  input logic bz_out,
  input logic lcd_clk
);
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!irq_flag && !lcd_clk);
  end

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> $stable(lcd_clk));

  assert_flag_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(tick_en));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_ack && !clr) |=> irq_flag);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!irq_flag && !lcd_clk));

  assert_bz_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bz_en |-> !bz_out);
endmodule

bind watch_buzz_timer wt_sva u_wt_sva (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(clr), .flag_ack(flag_ack),
  .bz_en(bz_en), .irq_flag(irq_flag), .bz_out(bz_out), .lcd_clk(lcd_clk)
);

// File: tb/sim_watch_buzz_timer.sv
module sim_watch_buzz_timer;
  logic       clk = 1'b0;
  logic       rst_n, tick_en, clr, ivl_sel, flag_ack, bz_en;
  logic [1:0] bz_sel;
  logic       irq_flag, bz_out, lcd_clk;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  watch_buzz_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(clr), .ivl_sel(ivl_sel),
    .flag_ack(flag_ack), .bz_en(bz_en), .bz_sel(bz_sel),
    .irq_flag(irq_flag), .bz_out(bz_out), .lcd_clk(lcd_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag", irq_flag, 0);
    chk("R1 bz", bz_out, 0);
    chk("R1 lcd", lcd_clk, 0);
  endtask

  task automatic t_lcd_and_gate();
    do_clr();
    ticks(31);
    chk("R3 lcd at 31", lcd_clk, 0);
    ticks(1);
    chk("R3 lcd at 32", lcd_clk, 1);
    repeat (50) @(negedge clk);  // no ticks
    chk("R2 lcd held", lcd_clk, 1);
    ticks(31);
    chk("R3 lcd at 63", lcd_clk, 1);
    ticks(1);
    chk("R3 lcd at 64", lcd_clk, 0);
  endtask

  task automatic t_fast();
    ivl_sel = 1'b1;
    do_clr();
    ticks(100);
    repeat (40) @(negedge clk);
    ticks(27);
    chk("R4/R2 flag at 127", irq_flag, 0);
    ticks(1);
    chk("R4 flag at 128", irq_flag, 1);
    ticks(300);
    chk("R6 flag sticky", irq_flag, 1);
    flag_ack = 1'b1;
    @(negedge clk);
    flag_ack = 1'b0;
    chk("R6 flag acked", irq_flag, 0);
    repeat (300) @(negedge clk);
    chk("R2 no tick no flag", irq_flag, 0);
  endtask

  task automatic t_ack_collide();
    ivl_sel = 1'b1;
    do_clr();
    ticks(127);
    tick_en  = 1'b1;
    flag_ack = 1'b1;
    @(negedge clk);
    tick_en  = 1'b0;
    flag_ack = 1'b0;
    chk("R6 set beats ack", irq_flag, 1);
    clr     = 1'b1;
    tick_en = 1'b1;
    @(negedge clk);
    clr     = 1'b0;
    tick_en = 1'b0;
    chk("R7 clr drops flag", irq_flag, 0);
    ticks(127);
    chk("R7 prescaler restarted", irq_flag, 0);
  endtask

  task automatic t_slow();
    ivl_sel = 1'b0;
    do_clr();
    ticks(128);
    chk("R5 no flag at 128", irq_flag, 0);
    ticks(16383 - 128);
    chk("R5 no flag at 16383", irq_flag, 0);
    ticks(1);
    chk("R5 flag at 16384", irq_flag, 1);
    do_clr();
  endtask

  task automatic t_bz_off();
    int hi = 0;
    bz_en  = 1'b0;
    bz_sel = 2'd3;
    do_clr();
    tick_en = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (bz_out) hi++;
    end
    tick_en = 1'b0;
    chk("R8 bz low when disabled", hi, 0);
  endtask

  task automatic t_bz_rates();
    for (int s = 0; s < 4; s++) begin
      int   rises = 0;
      logic prev;
      bz_en  = 1'b0;
      bz_sel = 2'(s);
      do_clr();
      bz_en   = 1'b1;
      prev    = bz_out;
      tick_en = 1'b1;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (bz_out && !prev) rises++;
        prev = bz_out;
      end
      tick_en = 1'b0;
      chk($sformatf("R9 rises for sel %0d", s), rises, 4 << s);
    end
  endtask

  task automatic t_bz_switch();
    bz_en  = 1'b1;
    bz_sel = 2'd0;
    do_clr();
    ticks(9);
    chk("R9 slow tap at 9", bz_out, 1);
    bz_sel = 2'd3;
    ticks(1);
    chk("R10 old tap kept at 10", bz_out, 1);
    ticks(1);
    chk("R10 new tap at 11", bz_out, 1);
    ticks(1);
    chk("R10 new tap at 12", bz_out, 0);
    bz_en = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    tick_en  = 1'b0;
    clr      = 1'b0;
    ivl_sel  = 1'b0;
    flag_ack = 1'b0;
    bz_en    = 1'b0;
    bz_sel   = 2'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lcd_and_gate();
    t_fast();
    t_ack_collide();
    t_slow();
    t_bz_off();
    t_bz_rates();
    t_bz_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule